// File: doc/BRIEF.md
# Text Mode Raster Scanout with Fine Scroll

This block turns a character buffer into a serial pixel stream for a raster panel. The screen is a grid of `COLS` character cells across and `TROWS` text rows down. Each cell is 8 by 8 pixels, so a raster line carries `COLS*8` pixels and the text window covers `TROWS*8` raster lines of a frame that is `LINES` lines tall. For each cell, the block reads a character code from an external text buffer. It then reads one glyph row byte from an external character generator memory and shifts that byte out, one pixel per cycle, with `dot_o` marking every cycle in which `pix_o` holds a pixel for the panel. A carriage return code ends the visible text of a raster line. A space code produces a blank cell without touching the glyph memory.

A window origin, made of a buffer text row and a pixel offset of 0 to 7 inside that row, allows the image to move up one raster line at a time. As a result the top and bottom text rows can appear only in part. The origin is captured while vertical sync is active, so a frame never mixes two origins. Text row indices wrap around the buffer. Raster lines below the text window are sent as blank lines.

The controller is one state machine. Its states are:
- SYNC_V: vertical sync pulse. The scroll origin is sampled here.
- SYNC_H: one-cycle horizontal sync that opens each raster line.
- RD_CHAR: character buffer read.
- DECODE: the code is inspected and a glyph read is issued.
- RD_GLYPH: the glyph byte is captured.
- EMIT: 8 pixels are shifted out, MSB first.
- FILL: blank pixels until the line is full.
- LINE_DONE: the raster and line position advance.
- RETRACE: the back porch after the last line.

The transitions are:
- SYNC_V→SYNC_H after `VS_LEN` cycles.
- SYNC_H→RD_CHAR inside the text window.
- SYNC_H→FILL below the text window.
- RD_CHAR→DECODE.
- DECODE→FILL on a carriage return.
- DECODE→EMIT on a space.
- DECODE→RD_GLYPH on any other code.
- RD_GLYPH→EMIT.
- EMIT→RD_CHAR at the end of a cell.
- EMIT→LINE_DONE at the end of the line.
- FILL→LINE_DONE at the end of the line.
- LINE_DONE→SYNC_H when more lines remain.
- LINE_DONE→RETRACE after the last line.
- RETRACE→SYNC_V after `PORCH_CYC` cycles.

Top module: `txt_scanout`

## Requirements
- R1: While `rst_n` is low, `dot_o`, `hsync_o`, `buf_rd_o` and `glyph_rd_o` are 0 and `vsync_o` is 1.
- R2: A frame starts with `vsync_o` high for exactly `VS_LEN` cycles. Each raster line starts with `hsync_o` high for one cycle. Sync outputs are never high in the same cycle as `dot_o`. After the last dot of a frame, `PORCH_CYC+1` cycles pass with all of `dot_o`, `hsync_o` and `vsync_o` low before `vsync_o` rises again.
- R3: The character for column c of buffer text row r is read from `buf_addr_o = r*COLS + c`, and the result is taken from `buf_data_i` one cycle later. Each text row feeds 8 consecutive raster lines, with the raster index rising by one per line.
- R4: A glyph byte is read from `glyph_addr_o = code*8 + raster`, and the result is taken from `glyph_data_i` one cycle later. Bit 7 is the leftmost pixel of the cell, and a 1 bit gives `pix_o = 1`.
- R5: Code 13 (carriage return) makes every remaining pixel of that raster line 0, the cell holding the code included.
- R6: Code 32 (space) gives 8 pixels of 0 and no glyph read. No glyph read is issued for code 13 or code 32.
- R7: Every raster line has exactly `COLS*8` cycles with `dot_o = 1`.
- R8: Every frame has exactly `LINES` horizontal sync pulses.
- R9: `scroll_row_i` and `scroll_fine_i` take effect only as sampled in the last `vsync_o` cycle. A change while `vsync_o` is low does not affect the current frame.
- R10: With origin row R and offset F, raster line L (for L < `TROWS*8`) shows raster index (F+L) mod 8 of buffer row R + (F+L) div 8. With F = 7, the top text row contributes only its glyph row 7.
- R11: Buffer text row numbers wrap modulo `BUF_ROWS` (a power of two).
- R12: Raster lines with index of `TROWS*8` or above are all 0 pixels and issue no buffer or glyph read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scroll_row_i | input | $clog2(BUF_ROWS) | Buffer text row at the top of the window |
| scroll_fine_i | input | 3 | First raster index shown of that row |
| buf_rd_o | output | 1 | Text buffer read strobe |
| buf_addr_o | output | $clog2(BUF_ROWS*COLS) | Text buffer address, row*COLS+column |
| buf_data_i | input | 8 | Character code, valid one cycle after the read |
| glyph_rd_o | output | 1 | Glyph memory read strobe |
| glyph_addr_o | output | 11 | Glyph address, code*8+raster |
| glyph_data_i | input | 8 | Glyph row byte, valid one cycle after the read |
| pix_o | output | 1 | Pixel value, 1 = lit |
| dot_o | output | 1 | Pixel strobe; the panel takes pix_o when high |
| hsync_o | output | 1 | Line start pulse |
| vsync_o | output | 1 | Frame start pulse |

## Verification
Some properties are checked on every cycle. These are:
- the exclusion between dot strobes and sync pulses;
- the count of dots in each line and of line pulses in each frame;
- single-cycle buffer reads;
- the step of the raster index and of the text row at each line end, including the wrap of the row.

Other behaviour can only be shown by the directed frames, which compare every captured pixel against a model built from the buffer contents. This covers the glyph bit order, the address formation, the blanking after a carriage return, the absence of glyph reads for spaces, the fine-offset window with wrap-around, the blank tail below the text window, and the fact that a mid-frame scroll change is ignored.

// File: rtl/txt_scan_pkg.sv
package txt_scan_pkg;

    typedef enum logic [3:0] {
        SYNC_V,
        SYNC_H,
        RD_CHAR,
        DECODE,
        RD_GLYPH,
        EMIT,
        FILL,
        LINE_DONE,
        RETRACE
    } scan_st_e;

    localparam logic [7:0] CODE_CR    = 8'd13;
    localparam logic [7:0] CODE_SPACE = 8'd32;
    localparam int         CELL       = 8;

endpackage

// File: rtl/txt_row_track.sv
module txt_row_track #(
    parameter int TROWS    = 16,
    parameter int BUF_ROWS = 32,
    parameter int LINES    = 256,
    localparam int RW      = $clog2(BUF_ROWS),
    localparam int LW      = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [RW-1:0] row_i,
    input  logic [2:0]    fine_i,
    input  logic          adv_i,
    output logic [RW-1:0] trow_o,
    output logic [2:0]    raster_o,
    output logic          text_area_o,
    output logic          last_line_o
);
    localparam int TEXT_LINES = TROWS * 8;

    logic [RW-1:0] trow_q;
    logic [2:0]    raster_q;
    logic [LW-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trow_q   <= '0;
            raster_q <= '0;
            line_q   <= '0;
        end else if (load_i) begin
            trow_q   <= row_i;
            raster_q <= fine_i;
            line_q   <= '0;
        end else if (adv_i) begin
            line_q <= line_q + 1'b1;
            if (raster_q == 3'd7) begin
                raster_q <= 3'd0;
                trow_q   <= trow_q + 1'b1;
            end else begin
                raster_q <= raster_q + 3'd1;
            end
        end
    end

    assign trow_o      = trow_q;
    assign raster_o    = raster_q;
    assign text_area_o = {1'b0, line_q} < (LW+1)'(TEXT_LINES);
    assign last_line_o = line_q == LW'(LINES - 1);

    // R3: raster index steps by one inside a text row
    p_raster_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && raster_q != 3'd7) |=>
            (raster_q == $past(raster_q) + 3'd1) && $stable(trow_q));

    // R11: leaving raster 7 moves to the next text row, modulo the buffer
    p_row_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && raster_q == 3'd7) |=>
            (raster_q == 3'd0) && (trow_q == RW'($past(trow_q) + 1'b1)));

endmodule

// File: rtl/txt_pix_shift.sv
module txt_pix_shift #(
    parameter int LINE_PIX = 256,
    localparam int PW      = $clog2(LINE_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic [7:0]    load_val_i,
    input  logic          shift_i,
    input  logic          dot_i,
    output logic          msb_o,
    output logic [PW-1:0] px_o,
    output logic          cell_end_o,
    output logic          line_end_o
);
    logic [7:0]    sh_q;
    logic [PW-1:0] px_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= load_val_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            px_q <= '0;
        end else if (dot_i) begin
            px_q <= px_q + 1'b1;
        end
    end

    assign msb_o      = sh_q[7];
    assign px_o       = px_q;
    assign cell_end_o = px_q[2:0] == 3'd7;
    assign line_end_o = px_q == PW'(LINE_PIX - 1);

    // R4: a shift moves the next glyph bit into the output position
    p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> sh_q[7] == $past(sh_q[6]));

endmodule

// File: rtl/txt_scanout.sv
module txt_scanout
    import txt_scan_pkg::*;
#(
    parameter int COLS      = 32,
    parameter int TROWS     = 16,
    parameter int LINES     = 256,
    parameter int BUF_ROWS  = 32,
    parameter int VS_LEN    = 4,
    parameter int PORCH_CYC = 1800,
    localparam int RW       = $clog2(BUF_ROWS),
    localparam int CW       = $clog2(COLS),
    localparam int AW       = RW + CW,
    localparam int LINE_PIX = COLS * CELL,
    localparam int PW       = $clog2(LINE_PIX),
    localparam int LW       = $clog2(LINES),
    localparam int GAW      = 8 + 3,
    localparam int TMAX     = (VS_LEN > PORCH_CYC) ? VS_LEN : PORCH_CYC,
    localparam int TW       = $clog2(TMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RW-1:0]  scroll_row_i,
    input  logic [2:0]     scroll_fine_i,
    output logic           buf_rd_o,
    output logic [AW-1:0]  buf_addr_o,
    input  logic [7:0]     buf_data_i,
    output logic           glyph_rd_o,
    output logic [GAW-1:0] glyph_addr_o,
    input  logic [7:0]     glyph_data_i,
    output logic           pix_o,
    output logic           dot_o,
    output logic           hsync_o,
    output logic           vsync_o
);
    scan_st_e state_q, nxt;
    logic [TW-1:0] tcnt_q;
    logic [RW-1:0] trow;
    logic [2:0]    raster;
    logic          text_area, last_line;
    logic          sh_msb, cell_end, line_end;
    logic [PW-1:0] px;
    logic          is_cr, is_space;
    logic          sh_load;
    logic [7:0]    sh_val;

    assign is_cr    = buf_data_i == CODE_CR;
    assign is_space = buf_data_i == CODE_SPACE;

    txt_row_track #(.TROWS(TROWS), .BUF_ROWS(BUF_ROWS), .LINES(LINES)) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (state_q == SYNC_V),
        .row_i       (scroll_row_i),
        .fine_i      (scroll_fine_i),
        .adv_i       (state_q == LINE_DONE),
        .trow_o      (trow),
        .raster_o    (raster),
        .text_area_o (text_area),
        .last_line_o (last_line)
    );

    assign sh_load = (state_q == RD_GLYPH) || (state_q == DECODE && is_space);
    assign sh_val  = (state_q == RD_GLYPH) ? glyph_data_i : 8'h00;

    txt_pix_shift #(.LINE_PIX(LINE_PIX)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (state_q == SYNC_H),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (state_q == EMIT),
        .dot_i      (dot_o),
        .msb_o      (sh_msb),
        .px_o       (px),
        .cell_end_o (cell_end),
        .line_end_o (line_end)
    );

    // State register and phase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SYNC_V;
            tcnt_q  <= '0;
        end else begin
            state_q <= nxt;
            tcnt_q  <= (nxt != state_q) ? '0 : tcnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            SYNC_V:    if (tcnt_q == TW'(VS_LEN - 1)) nxt = SYNC_H;
            SYNC_H:    nxt = text_area ? RD_CHAR : FILL;
            RD_CHAR:   nxt = DECODE;
            DECODE:    nxt = is_cr ? FILL : (is_space ? EMIT : RD_GLYPH);
            RD_GLYPH:  nxt = EMIT;
            EMIT:      if (cell_end) nxt = line_end ? LINE_DONE : RD_CHAR;
            FILL:      if (line_end) nxt = LINE_DONE;
            LINE_DONE: nxt = last_line ? RETRACE : SYNC_H;
            RETRACE:   if (tcnt_q == TW'(PORCH_CYC - 1)) nxt = SYNC_V;
            default:   nxt = SYNC_V;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        vsync_o      = state_q == SYNC_V;
        hsync_o      = state_q == SYNC_H;
        dot_o        = (state_q == EMIT) || (state_q == FILL);
        pix_o        = (state_q == EMIT) && sh_msb;
        buf_rd_o     = state_q == RD_CHAR;
        buf_addr_o   = {trow, px[PW-1:3]};
        glyph_rd_o   = (state_q == DECODE) && !is_cr && !is_space;
        glyph_addr_o = {buf_data_i, raster};
    end

    // Checker counters for per-line and per-frame totals
    logic [PW:0] dots_q;
    logic [LW:0] hs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dots_q <= '0;
            hs_q   <= '0;
        end else begin
            if (hsync_o)    dots_q <= '0;
            else if (dot_o) dots_q <= dots_q + 1'b1;
            if (vsync_o)      hs_q <= '0;
            else if (hsync_o) hs_q <= hs_q + 1'b1;
        end
    end

    p_dot_no_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dot_o |-> (!hsync_o && !vsync_o));

    p_line_dots_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LINE_DONE) |-> (dots_q == (PW+1)'(LINE_PIX)));

    p_frame_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RETRACE) |-> (hs_q == (LW+1)'(LINES)));

    p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> !buf_rd_o);

    p_tail_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o && !text_area) |=> (dot_o && !pix_o));

endmodule

// File: tb/txt_scanout_tb.sv
module txt_scanout_tb;
    localparam int COLS = 8, TROWS = 4, LINES = 48, BUF_ROWS = 8;
    localparam int VS_LEN = 3, PORCH_CYC = 20;
    localparam int LINE_PIX = COLS * 8, TEXT_LINES = TROWS * 8;
    localparam int RW = $clog2(BUF_ROWS), AW = $clog2(BUF_ROWS * COLS);

    logic clk = 0, rst_n = 0;
    logic [RW-1:0] scroll_row = '0;
    logic [2:0] scroll_fine = '0;
    logic buf_rd, glyph_rd, pix, dot, hs, vs;
    logic [AW-1:0] buf_addr;
    logic [10:0] glyph_addr;
    logic [7:0] buf_q = 0, gly_q = 0;
    logic [7:0] bmem [0:BUF_ROWS*COLS-1];

    always #5 clk = ~clk;

    txt_scanout #(.COLS(COLS), .TROWS(TROWS), .LINES(LINES), .BUF_ROWS(BUF_ROWS),
                  .VS_LEN(VS_LEN), .PORCH_CYC(PORCH_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scroll_row_i(scroll_row), .scroll_fine_i(scroll_fine),
        .buf_rd_o(buf_rd), .buf_addr_o(buf_addr), .buf_data_i(buf_q),
        .glyph_rd_o(glyph_rd), .glyph_addr_o(glyph_addr), .glyph_data_i(gly_q),
        .pix_o(pix), .dot_o(dot), .hsync_o(hs), .vsync_o(vs));

    function automatic logic [7:0] gfun(input logic [7:0] code, input logic [2:0] r);
        logic [7:0] t;
        if (code == 8'd65) begin
            case (r)
                3'd0: t = 8'h08; 3'd1: t = 8'h14; 3'd4: t = 8'h3E; 3'd7: t = 8'h00;
                default: t = 8'h22;
            endcase
        end else begin
            t = code * 8'd13 + {5'd0, r} * 8'd57 + 8'h5A;
        end
        return t;
    endfunction

    always @(posedge clk) begin
        if (buf_rd) buf_q <= bmem[buf_addr];
        if (glyph_rd) gly_q <= gfun(glyph_addr[10:3], glyph_addr[2:0]);
    end

    // Monitor, sampling on the falling edge
    bit cap [0:LINES-1][0:LINE_PIX-1];
    int line_px [0:LINES-1];
    int frame_id = 0, line_idx = -1, px_idx = 0, done_lines = 0;
    int idle = 0, gap_last = 0, vs_run = 0, vs_len_last = 0;
    int bad_glyph = 0, bad_glyph_last = 0, tail_rd = 0, tail_rd_last = 0;
    logic vs_prev = 0, hs_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (vs && !vs_prev) begin
                frame_id++;
                done_lines = line_idx + 1;
                gap_last = idle;
                bad_glyph_last = bad_glyph; bad_glyph = 0;
                tail_rd_last = tail_rd; tail_rd = 0;
                line_idx = -1;
            end
            if (vs) vs_run++;
            else if (vs_prev) begin vs_len_last = vs_run; vs_run = 0; end
            if (hs && !hs_prev) begin
                line_idx++;
                px_idx = 0;
                if (line_idx < LINES) line_px[line_idx] = 0;
            end
            if (dot && line_idx >= 0 && line_idx < LINES) begin
                if (px_idx < LINE_PIX) cap[line_idx][px_idx] = pix;
                px_idx++;
                line_px[line_idx]++;
            end
            if (!vs && !hs && !dot) idle++; else idle = 0;
            if (glyph_rd && (glyph_addr[10:3] == 8'd13 || glyph_addr[10:3] == 8'd32)) bad_glyph++;
            if ((buf_rd || glyph_rd) && line_idx >= TEXT_LINES) tail_rd++;
            vs_prev = vs; hs_prev = hs;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_pix(int line, int x, int row0, int f);
        int t, tr, rr, c;
        logic [7:0] code, g;
        if (line >= TEXT_LINES) return 1'b0;
        t = f + line; tr = (row0 + t / 8) % BUF_ROWS; rr = t % 8; c = x / 8;
        for (int k = 0; k <= c; k++) if (bmem[tr*COLS + k] == 8'd13) return 1'b0;
        code = bmem[tr*COLS + c];
        if (code == 8'd32) return 1'b0;
        g = gfun(code, 3'(rr));
        return g[7 - (x % 8)];
    endfunction

    task automatic wait_frame();
        int f = frame_id;
        while (frame_id == f) @(posedge clk);
        #1;
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < BUF_ROWS * COLS; i++) bmem[i] = 8'(33 + ((i * 7 + 32) % 90));
        bmem[1] = 8'd65;
        if (mode == 1) begin
            for (int r = 0; r < BUF_ROWS; r += 2) begin
                bmem[r*COLS + 1] = 8'd32; bmem[r*COLS + 3] = 8'd13;
            end
            bmem[1*COLS + 0] = 8'd13;
            bmem[3*COLS + 6] = 8'd32; bmem[3*COLS + 7] = 8'd13;
        end
    endtask

    task automatic check_frame(input int row0, input int f, input string tag);
        int bad_len = 0, first_bad = -1, mis, mx;
        chk(done_lines == LINES, "R8", "lines per frame", done_lines, LINES);
        chk(vs_len_last == VS_LEN, "R2", "vsync length", vs_len_last, VS_LEN);
        chk(gap_last == PORCH_CYC + 1, "R2", "retrace idle cycles", gap_last, PORCH_CYC + 1);
        chk(bad_glyph_last == 0, "R6", "glyph reads of code 13/32", bad_glyph_last, 0);
        chk(tail_rd_last == 0, "R12", "reads below text window", tail_rd_last, 0);
        for (int l = 0; l < LINES; l++) if (line_px[l] != LINE_PIX) begin
            bad_len++; if (first_bad < 0) first_bad = l;
        end
        chk(bad_len == 0, "R7", $sformatf("dots per line (first bad line %0d)", first_bad),
            (first_bad < 0) ? LINE_PIX : line_px[first_bad], LINE_PIX);
        for (int l = 0; l < LINES; l++) begin
            mis = 0; mx = -1;
            for (int x = 0; x < LINE_PIX; x++) if (cap[l][x] != exp_pix(l, x, row0, f)) begin
                mis++; if (mx < 0) mx = x;
            end
            chk(mis == 0, (l >= TEXT_LINES) ? "R12" : tag,
                $sformatf("line %0d pixel %0d", l, mx),
                (mx < 0) ? 0 : int'(cap[l][mx]), (mx < 0) ? 0 : int'(exp_pix(l, mx, row0, f)));
        end
    endtask

    task automatic run_frame(input int row0, input int f, input int mode, input bit chg, input string tag);
        wait_frame();
        while (line_idx < 1) begin @(posedge clk); #1; end
        fill(mode);
        scroll_row = RW'(row0); scroll_fine = 3'(f);
        wait_frame();
        if (chg) begin
            while (line_idx < 3) begin @(posedge clk); #1; end
            scroll_row = RW'(row0 + 3); scroll_fine = 3'(f + 3);
        end
        wait_frame();
        check_frame(row0, f, tag);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(dot == 0, "R1", "dot in reset", dot, 0);
        chk(hs == 0, "R1", "hsync in reset", hs, 0);
        chk(vs == 1, "R1", "vsync in reset", vs, 1);
        chk(buf_rd == 0 && glyph_rd == 0, "R1", "reads in reset", buf_rd | glyph_rd, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(posedge clk);
        test_reset();
        @(posedge clk); #1 rst_n = 1;
        run_frame(0, 0, 0, 1'b0, "R3 R4 plain glyphs");
        run_frame(0, 3, 1, 1'b0, "R5 R6 carriage return and space");
        run_frame(BUF_ROWS - 2, 7, 0, 1'b0, "R10 R11 fine offset with wrap");
        run_frame(3, 2, 1, 1'b1, "R9 mid-frame scroll change ignored");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule